// File: doc/BRIEF.md
# Packet-Filter Instruction Slot Decoder

This block sits behind an instruction fetch path for a 64-bit register-machine packet-filter program. It accepts one 64-bit instruction slot per cycle over a valid/ready handshake and produces one decoded instruction record per architectural instruction: the class, the operation code, the register/immediate source select, the load/store mode and access size, the two register indices, and the offset and immediate sign-extended to 64 bits. Each record carries the index of the slot that started it.

A static mode input selects how the slot bytes are read. In one mode the register byte carries the destination in its low nibble and multi-byte fields are little-endian; in the other the nibbles swap and the fields are big-endian. One encoding, the wide immediate load, spans two consecutive slots; the block holds the first, merges the second slot's immediate into the upper half of a 64-bit constant, and emits a single record. Undefined classes, reserved load/store modes and a wide load whose second half stops arriving are reported on an illegal-instruction strobe instead of the valid strobe.

Top module: `pf_slot_decoder`

## Requirements
- R1: Slot byte k occupies `slot_data[8k+7:8k]`; byte 0 is the code byte. `dec_class` = code[2:0], `dec_opcode` = code[7:4], `dec_srcsel` = code[3] (0 immediate, 1 register), `dec_mode` = code[7:5], `dec_size` = code[4:3] (00 four bytes, 01 two, 10 one, 11 eight).
- R2: With `big_endian` = 0, `dec_dst` = byte1[3:0], `dec_src` = byte1[7:4], the offset is {byte3, byte2} and the immediate is {byte7, byte6, byte5, byte4}.
- R3: With `big_endian` = 1, `dec_dst` = byte1[7:4], `dec_src` = byte1[3:0], the offset is {byte2, byte3} and the immediate is {byte4, byte5, byte6, byte7}.
- R4: For a one-slot instruction, `dec_offset` and `dec_imm` are the 16-bit offset and 32-bit immediate sign-extended to 64 bits.
- R5: A legal one-slot instruction raises `dec_valid` for exactly one cycle, in the cycle after the clock edge that accepts it; `dec_slot` is the count of slots accepted since reset before it (first slot is 0).
- R6: Code byte 0x18 (class 000, size 11, mode 000) is a wide load: its slot produces no strobe; on acceptance of the next slot `dec_valid` and `dec_wide` rise with `dec_imm` = {second immediate, first immediate}, the other fields and `dec_slot` taken from the first slot. The second slot may arrive up to WAIT_LIMIT-1 idle cycles later.
- R7: Class 110, or a class in 000..011 with mode 100 or 101, raises `dec_illegal` for one cycle instead of `dec_valid`; mode 100/101 under the other classes is legal.
- R8: If no slot is accepted for WAIT_LIMIT consecutive cycles after a wide load's first slot, `dec_illegal` rises with `dec_wide` = 1 and that slot's `dec_slot`; the next slot is decoded as a fresh instruction.
- R9: In reset `slot_ready`, `dec_valid` and `dec_illegal` are low and the slot count returns to zero.
- R10: Out of reset `slot_ready` is high; cycles with `slot_valid` low produce no strobe and do not advance the slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Static slot byte-order and nibble-order select |
| slot_valid | input | 1 | Slot present |
| slot_data | input | 64 | Instruction slot |
| slot_ready | output | 1 | Slot accepted when high with slot_valid |
| dec_valid | output | 1 | One-cycle strobe: legal decoded instruction |
| dec_illegal | output | 1 | One-cycle strobe: illegal encoding or abandoned wide load |
| dec_wide | output | 1 | Record came from a two-slot wide load |
| dec_class | output | 3 | Instruction class |
| dec_opcode | output | 4 | Arithmetic/jump operation code |
| dec_srcsel | output | 1 | Source select |
| dec_mode | output | 3 | Load/store mode |
| dec_size | output | 2 | Load/store access size |
| dec_dst | output | 4 | Destination register index |
| dec_src | output | 4 | Source register index |
| dec_offset | output | 64 | Sign-extended offset |
| dec_imm | output | 64 | Sign-extended or merged 64-bit immediate |
| dec_slot | output | SLOT_W | Index of the instruction's first slot |

## Verification
The assertions assume `big_endian` holds steady while a wide load is waiting for its second slot and that `slot_valid` and `slot_data` carry known values once reset is released. The bench only changes the byte-order select between complete instructions with `slot_valid` low, and drives every slot as a fully defined word built from the field layout of R1 to R3. The idle-window property counts idle cycles in the checker rather than through a long delay, so it stays valid for any WAIT_LIMIT.

// File: rtl/pf_slot_decoder.sv
module pf_slot_decoder #(
  parameter int SLOT_W     = 16,
  parameter int WAIT_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              slot_valid,
  input  logic [63:0]       slot_data,
  output logic              slot_ready,
  output logic              dec_valid,
  output logic              dec_illegal,
  output logic              dec_wide,
  output logic [2:0]        dec_class,
  output logic [3:0]        dec_opcode,
  output logic              dec_srcsel,
  output logic [2:0]        dec_mode,
  output logic [1:0]        dec_size,
  output logic [3:0]        dec_dst,
  output logic [3:0]        dec_src,
  output logic [63:0]       dec_offset,
  output logic [63:0]       dec_imm,
  output logic [SLOT_W-1:0] dec_slot
);

  localparam int CNT_W = $clog2(WAIT_LIMIT + 1);
  localparam logic [7:0] WIDE_CODE = 8'h18;

  logic              pending;
  logic [CNT_W-1:0]  wait_cnt;
  logic [SLOT_W-1:0] slot_cnt;

  logic [7:0]  code, regs;
  logic [15:0] off_raw;
  logic [31:0] imm_raw;
  logic        accept, is_wide, is_bad, ldst_class, rsvd_mode;

  assign slot_ready = rst_n;
  assign accept     = slot_valid && slot_ready;

  assign code    = slot_data[7:0];
  assign regs    = slot_data[15:8];
  assign off_raw = big_endian ? {slot_data[23:16], slot_data[31:24]} : slot_data[31:16];
  assign imm_raw = big_endian ? {slot_data[39:32], slot_data[47:40],
                                 slot_data[55:48], slot_data[63:56]}
                              : slot_data[63:32];

  assign is_wide    = (code == WIDE_CODE);
  assign ldst_class = (code[2] == 1'b0);
  assign rsvd_mode  = (code[7:5] == 3'b100) || (code[7:5] == 3'b101);
  assign is_bad     = (code[2:0] == 3'b110) || (ldst_class && rsvd_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      wait_cnt    <= '0;
      slot_cnt    <= '0;
      dec_valid   <= 1'b0;
      dec_illegal <= 1'b0;
      dec_wide    <= 1'b0;
      dec_class   <= '0;
      dec_opcode  <= '0;
      dec_srcsel  <= 1'b0;
      dec_mode    <= '0;
      dec_size    <= '0;
      dec_dst     <= '0;
      dec_src     <= '0;
      dec_offset  <= '0;
      dec_imm     <= '0;
      dec_slot    <= '0;
    end else begin
      dec_valid   <= 1'b0;
      dec_illegal <= 1'b0;
      if (accept) slot_cnt <= slot_cnt + SLOT_W'(1);

      if (accept && pending) begin
        pending   <= 1'b0;
        dec_valid <= 1'b1;
        dec_imm   <= {imm_raw, dec_imm[31:0]};
      end else if (accept) begin
        dec_class  <= code[2:0];
        dec_opcode <= code[7:4];
        dec_srcsel <= code[3];
        dec_mode   <= code[7:5];
        dec_size   <= code[4:3];
        dec_dst    <= big_endian ? regs[7:4] : regs[3:0];
        dec_src    <= big_endian ? regs[3:0] : regs[7:4];
        dec_offset <= {{48{off_raw[15]}}, off_raw};
        dec_imm    <= is_wide ? {32'd0, imm_raw} : {{32{imm_raw[31]}}, imm_raw};
        dec_slot   <= slot_cnt;
        dec_wide   <= is_wide;
        if (is_wide) begin
          pending  <= 1'b1;
          wait_cnt <= '0;
        end else if (is_bad) begin
          dec_illegal <= 1'b1;
        end else begin
          dec_valid <= 1'b1;
        end
      end else if (pending) begin
        if (wait_cnt == CNT_W'(WAIT_LIMIT - 1)) begin
          pending     <= 1'b0;
          dec_illegal <= 1'b1;
        end else begin
          wait_cnt <= wait_cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pf_slot_decoder_checker.sv
module pf_slot_decoder_checker #(
  parameter int WAIT_LIMIT = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        slot_valid,
  input logic        slot_ready,
  input logic        pending,
  input logic        dec_valid,
  input logic        dec_illegal,
  input logic        dec_wide,
  input logic [2:0]  dec_class,
  input logic [2:0]  dec_mode,
  input logic [1:0]  dec_size,
  input logic [63:0] dec_offset,
  input logic [63:0] dec_imm
);

  int idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !pending) idle_cnt <= 0;
    else if (slot_valid && slot_ready) idle_cnt <= 0;
    else idle_cnt <= idle_cnt + 1;
  end

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_valid && dec_illegal));

  p_pulse_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(slot_valid && slot_ready));

  p_offset_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_offset[63:16] == {48{dec_offset[15]}}));

  p_imm_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_wide) |-> (dec_imm[63:32] == {32{dec_imm[31]}}));

  p_wide_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_wide) |-> (dec_class == 3'b000 && dec_size == 2'b11 && dec_mode == 3'b000));

  p_legal_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_class != 3'b110 &&
                   !(dec_class[2] == 1'b0 && (dec_mode == 3'b100 || dec_mode == 3'b101))));

  p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (idle_cnt < WAIT_LIMIT));

  p_ready_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ready);

endmodule

bind pf_slot_decoder pf_slot_decoder_checker #(.WAIT_LIMIT(WAIT_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ready(slot_ready),
  .pending(pending), .dec_valid(dec_valid), .dec_illegal(dec_illegal),
  .dec_wide(dec_wide), .dec_class(dec_class), .dec_mode(dec_mode),
  .dec_size(dec_size), .dec_offset(dec_offset), .dec_imm(dec_imm));

// File: tb/pf_slot_decoder_bench.sv
`timescale 1ns/1ps
module pf_slot_decoder_bench;
  localparam int LIM = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, big_endian, slot_valid;
  logic [63:0] slot_data;
  logic        slot_ready, dec_valid, dec_illegal, dec_wide, dec_srcsel;
  logic [2:0]  dec_class, dec_mode;
  logic [3:0]  dec_opcode, dec_dst, dec_src;
  logic [1:0]  dec_size;
  logic [63:0] dec_offset, dec_imm;
  logic [15:0] dec_slot;

  pf_slot_decoder #(.SLOT_W(16), .WAIT_LIMIT(LIM)) u_pf_slot_decoder (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .slot_valid(slot_valid),
    .slot_data(slot_data), .slot_ready(slot_ready), .dec_valid(dec_valid),
    .dec_illegal(dec_illegal), .dec_wide(dec_wide), .dec_class(dec_class),
    .dec_opcode(dec_opcode), .dec_srcsel(dec_srcsel), .dec_mode(dec_mode),
    .dec_size(dec_size), .dec_dst(dec_dst), .dec_src(dec_src),
    .dec_offset(dec_offset), .dec_imm(dec_imm), .dec_slot(dec_slot));

  int errors = 0, checks = 0, exp_slot = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] code, input logic [3:0] dst,
      input logic [3:0] src, input logic [15:0] off, input logic [31:0] imm, input bit be);
    if (!be) return {imm, off, src, dst, code};
    return {imm[7:0], imm[15:8], imm[23:16], imm[31:24], off[7:0], off[15:8], dst, src, code};
  endfunction

  task automatic push(input logic [63:0] d);
    @(negedge clk);
    slot_valid = 1'b1;
    slot_data  = d;
    @(posedge clk);
    #1;
    slot_valid = 1'b0;
    exp_slot++;
  endtask

  task automatic expect_rec(input string tag, input bit ill, input logic [7:0] code,
      input logic [3:0] dst, input logic [3:0] src, input logic [63:0] off,
      input logic [63:0] imm, input bit wide, input int slot);
    chk({tag, " valid"}, dec_valid, !ill);
    chk({tag, " illegal"}, dec_illegal, ill);
    chk({tag, " class R1"}, dec_class, code[2:0]);
    chk({tag, " opcode R1"}, dec_opcode, code[7:4]);
    chk({tag, " srcsel R1"}, dec_srcsel, code[3]);
    chk({tag, " mode R1"}, dec_mode, code[7:5]);
    chk({tag, " size R1"}, dec_size, code[4:3]);
    chk({tag, " dst"}, dec_dst, dst);
    chk({tag, " src"}, dec_src, src);
    chk({tag, " offset"}, dec_offset, off);
    chk({tag, " imm"}, dec_imm, imm);
    chk({tag, " wide"}, dec_wide, wide);
    chk({tag, " slot R5"}, dec_slot, 64'(slot));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; big_endian = 1'b0; slot_valid = 1'b0; slot_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 ready in reset", slot_ready, 0);
    chk("R9 valid in reset", dec_valid, 0);
    chk("R9 illegal in reset", dec_illegal, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 ready after reset", slot_ready, 1);
  endtask

  task automatic t_le_alu();
    int s = exp_slot;
    push(mk(8'h0F, 4'd3, 4'd5, 16'hFFFE, 32'h8000_0001, 0));
    expect_rec("R2 R4 LE alu", 0, 8'h0F, 4'd3, 4'd5, 64'hFFFF_FFFF_FFFF_FFFE,
               64'hFFFF_FFFF_8000_0001, 0, s);
    @(posedge clk); #1;
    chk("R5 pulse one cycle", dec_valid, 0);
  endtask

  task automatic t_be_alu();
    int s = exp_slot;
    big_endian = 1'b1;
    push(mk(8'h0F, 4'd3, 4'd5, 16'hFFFE, 32'h8000_0001, 1));
    expect_rec("R3 BE alu", 0, 8'h0F, 4'd3, 4'd5, 64'hFFFF_FFFF_FFFF_FFFE,
               64'hFFFF_FFFF_8000_0001, 0, s);
    s = exp_slot;
    push(mk(8'h5D, 4'd10, 4'd1, 16'h7FFF, 32'h1234_5678, 1));
    expect_rec("R3 BE jump", 0, 8'h5D, 4'd10, 4'd1, 64'h7FFF, 64'h1234_5678, 0, s);
    big_endian = 1'b0;
  endtask

  task automatic t_ldst();
    int s = exp_slot;
    push(mk(8'h69, 4'd2, 4'd9, 16'h0010, 32'h0000_0000, 0));
    expect_rec("R1 load mem half", 0, 8'h69, 4'd2, 4'd9, 64'h10, 64'h0, 0, s);
    s = exp_slot;
    push(mk(8'h84, 4'd7, 4'd0, 16'h0000, 32'h7FFF_FFFF, 0));
    expect_rec("R7 alu mode bits legal", 0, 8'h84, 4'd7, 4'd0, 64'h0, 64'h7FFF_FFFF, 0, s);
  endtask

  task automatic t_illegal();
    int s = exp_slot;
    push(mk(8'h06, 4'd1, 4'd2, 16'h0003, 32'h0000_0004, 0));
    expect_rec("R7 class 110", 1, 8'h06, 4'd1, 4'd2, 64'h3, 64'h4, 0, s);
    s = exp_slot;
    push(mk(8'h81, 4'd1, 4'd2, 16'h0000, 32'h0000_0000, 0));
    expect_rec("R7 mode 100", 1, 8'h81, 4'd1, 4'd2, 64'h0, 64'h0, 0, s);
    s = exp_slot;
    push(mk(8'hB2, 4'd4, 4'd0, 16'h8000, 32'h0000_0000, 0));
    expect_rec("R7 mode 101", 1, 8'hB2, 4'd4, 4'd0, 64'hFFFF_FFFF_FFFF_8000, 64'h0, 0, s);
  endtask

  task automatic t_wide(input bit be, input int gap);
    int s = exp_slot;
    big_endian = be;
    push(mk(8'h18, 4'd6, 4'd0, 16'h0000, 32'h89AB_CDEF, be));
    chk("R6 first half silent valid", dec_valid, 0);
    chk("R6 first half silent illegal", dec_illegal, 0);
    repeat (gap) @(posedge clk);
    #1;
    push(mk(8'h00, 4'd0, 4'd0, 16'h0000, 32'h0123_4567, be));
    expect_rec(be ? "R6 wide BE" : "R6 wide LE", 0, 8'h18, 4'd6, 4'd0, 64'h0,
               64'h0123_4567_89AB_CDEF, 1, s);
    big_endian = 1'b0;
  endtask

  task automatic t_timeout();
    int s = exp_slot;
    int seen = 0;
    push(mk(8'h18, 4'd8, 4'd0, 16'h0000, 32'h0000_0042, 0));
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk); #1;
      if (dec_illegal && seen == 0) seen = k;
      if (seen != 0) break;
    end
    chk("R8 timeout cycles", 64'(seen), 64'(LIM));
    chk("R8 timeout wide flag", dec_wide, 1);
    chk("R8 timeout slot", dec_slot, 64'(s));
    s = exp_slot;
    push(mk(8'h07, 4'd1, 4'd0, 16'h0000, 32'h0000_0005, 0));
    expect_rec("R8 fresh after timeout", 0, 8'h07, 4'd1, 4'd0, 64'h0, 64'h5, 0, s);
  endtask

  task automatic t_idle();
    int s;
    int strobes = 0;
    @(negedge clk);
    slot_data = mk(8'h0F, 4'd1, 4'd1, 16'h1, 32'h1, 0);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      if (dec_valid || dec_illegal) strobes++;
    end
    chk("R10 idle no strobe", 64'(strobes), 0);
    s = exp_slot;
    push(mk(8'h0F, 4'd2, 4'd3, 16'h0, 32'h0, 0));
    expect_rec("R10 slot count unchanged by idle", 0, 8'h0F, 4'd2, 4'd3, 64'h0, 64'h0, 0, s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_le_alu();
    t_be_alu();
    t_ldst();
    t_illegal();
    t_wide(0, 0);
    t_wide(1, 3);
    t_wide(0, LIM - 1);
    t_timeout();
    t_idle();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule